// File: doc/BRIEF.md
# Host DMA Byte-Assembly Sequencer

This block sits on the host side of a parallel host port and feeds words to the local processor under an external DMA controller. It raises a request whenever its byte registers can take data. The DMA controller answers each request with an acknowledge strobe and a byte on the host data bus. A lane counter chooses which byte register that acknowledged cycle writes. When the lowest-order lane has been written, the assembled word moves into a receive holding register and a full flag rises. A read strobe from the local side lowers that flag.

A two-bit mode input selects how words are formed. Mode 01 packs 8-bit words: one byte per word, written into the low lane only. Mode 10 packs 16-bit words: the high lane first, then the low lane. Modes 00 and 11 turn DMA off. The counter post-increments after every lane except the last. After the last lane it reloads from the mode, so every word starts on the correct lane. A finished word waits in the byte registers, with the request held low, until the receive register is empty.

The handshake controller has four states. IDLE is entered on reset and whenever the mode is off; the counter reloads here, and the block moves to REQ once a mode is selected. REQ drives the request. It returns to IDLE if the mode turns off. On an acknowledge it writes a byte and moves to REL for a non-final lane, or to XFER for the final lane. XFER waits for the receive register to be empty, commits the word, and then moves to REL. REL waits for the acknowledge to drop, then moves to REQ if a mode is on, or to IDLE if not.

Top module: `hdma_word_packer`

## Requirements
- R1: `req_o` is high only in the request state while the byte registers are empty. With mode 00 or 11 the request stays low and acknowledges are ignored.
- R2: An acknowledge seen while `req_o` is high writes `hdata_i` into the lane the counter selects. `req_o` is low in the next cycle.
- R3: After a non-final lane is written, the counter advances by one. `req_o` stays low while the acknowledge is held, and rises in the cycle after the acknowledge is seen low.
- R4: Writing the final (low) lane drives `tx_empty_o` to 0 and reloads the counter with the first lane of the current mode.
- R5: When the receive register is empty, the word commits in the cycle after the final write. `rx_word_o` becomes {high lane, low lane}, `rx_full_o` becomes 1, and `tx_empty_o` returns to 1.
- R6: While `rx_full_o` is 1 and a finished word is waiting, `req_o` stays low, `tx_empty_o` stays 0, and `rx_word_o` holds its value until a read strobe arrives.
- R7: Mode 01 writes one byte per word into the low lane, and the high half of the word keeps the last value written to the high lane. Mode 10 takes the first byte into the high lane and the second into the low lane.
- R8: A `rd_i` pulse with no commit in the same cycle clears `rx_full_o` in the next cycle.
- R9: Synchronous reset clears the byte registers, `rx_word_o` and `rx_full_o`, sets `tx_empty_o` to 1, holds `req_o` low, and loads the counter from the mode, so a word begun before reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Packing mode: 01 8-bit, 10 16-bit, 00/11 off |
| ack_i | input | 1 | Acknowledge from the DMA controller |
| hdata_i | input | 8 | Host data bus byte |
| req_o | output | 1 | DMA request to the controller |
| rd_i | input | 1 | Local-side read strobe of the receive register |
| rx_word_o | output | 16 | Receive holding register |
| rx_full_o | output | 1 | Receive register holds an unread word |
| tx_empty_o | output | 1 | Byte registers can accept data |

## Verification
The bench builds the block with its defaults: 8-bit lanes and two lanes, which gives a 16-bit receive word. These values cover both packing modes. They also cover the case where an 8-bit word inherits a stale high byte, and the lane reload after the final lane and after reset. A vector table alternates 8-bit and 16-bit words and varies acknowledge delays, hold times and local read stalls. Some words are left unread on purpose, so the next word has to stall at commit. Directed tests then cover a reset in the middle of a word, acknowledges issued while the mode is off, and the reserved mode.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_REL  = 2'd2,
        ST_XFER = 2'd3
    } hs_state_e;

    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_8B  = 2'b01;
    localparam logic [1:0] MODE_16B = 2'b10;

    function automatic logic mode_on(input logic [1:0] m);
        return (m == MODE_8B) || (m == MODE_16B);
    endfunction

    // lane 0 is the most significant; the final lane is the low byte
    function automatic int unsigned first_lane(input logic [1:0] m, input int unsigned n);
        if (m == MODE_16B)
            return n - 2;
        return n - 1;
    endfunction

endpackage

// File: rtl/hdma_lane_ctr.sv
module hdma_lane_ctr #(
    parameter int unsigned NUM_LANES = 2,
    localparam int unsigned LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        mode_i,
    input  logic              reload_i,
    input  logic              step_i,
    output logic [LANE_W-1:0] lane_o,
    output logic              is_last_o
);
    import hdma_pkg::*;

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] start_lane;

    assign start_lane = LANE_W'(first_lane(mode_i, NUM_LANES));

    always_ff @(posedge clk_i) begin
        if (rst_i || reload_i)
            lane_q <= start_lane;
        else if (step_i)
            lane_q <= lane_q + 1'b1;
    end

    assign lane_o    = lane_q;
    assign is_last_o = (lane_q == LAST_LANE);

    // R3
    lane_advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !reload_i) |=> (lane_q == $past(lane_q) + 1'b1));

endmodule

// File: rtl/hdma_byte_bank.sv
module hdma_byte_bank #(
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned NUM_LANES = 2,
    localparam int unsigned LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int unsigned WORD_W = BYTE_W * NUM_LANES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic              fill_done_i,
    input  logic              commit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              tx_empty_o
);

    logic tx_empty_q;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk_i) begin
            if (rst_i)
                byte_q <= '0;
            else if (wr_en_i && (lane_i == LANE_W'(k)))
                byte_q <= din_i;
        end
        assign word_o[(NUM_LANES-1-k)*BYTE_W +: BYTE_W] = byte_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            tx_empty_q <= 1'b1;
        else if (fill_done_i)
            tx_empty_q <= 1'b0;
        else if (commit_i)
            tx_empty_q <= 1'b1;
    end

    assign tx_empty_o = tx_empty_q;

    // R2
    write_when_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |-> tx_empty_q);

    // R4
    fill_clears_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        fill_done_i |=> !tx_empty_q);

endmodule

// File: rtl/hdma_rx_hold.sv
module hdma_rx_hold #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              rd_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_full_o
);

    logic [WORD_W-1:0] rx_q;
    logic              full_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rx_q   <= '0;
            full_q <= 1'b0;
        end else if (commit_i) begin
            rx_q   <= word_i;
            full_q <= 1'b1;
        end else if (rd_i) begin
            full_q <= 1'b0;
        end
    end

    assign rx_word_o = rx_q;
    assign rx_full_o = full_q;

    // R5
    commit_into_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_i |-> !full_q);

    // R6
    hold_while_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (full_q && !rd_i) |=> (full_q && $stable(rx_q)));

    // R8
    read_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !commit_i) |=> !full_q);

endmodule

// File: rtl/hdma_hs_fsm.sv
module hdma_hs_fsm (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] mode_i,
    input  logic       ack_i,
    input  logic       tx_empty_i,
    input  logic       rx_full_i,
    input  logic       is_last_i,
    output logic       req_o,
    output logic       wr_en_o,
    output logic       step_o,
    output logic       reload_o,
    output logic       fill_done_o,
    output logic       commit_o
);
    import hdma_pkg::*;

    hs_state_e state_q, state_d;
    logic      en;

    assign en = mode_on(mode_i);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = ST_REQ;
            ST_REQ: begin
                if (!en)
                    state_d = ST_IDLE;
                else if (ack_i)
                    state_d = is_last_i ? ST_XFER : ST_REL;
            end
            ST_REL:  if (!ack_i) state_d = en ? ST_REQ : ST_IDLE;
            ST_XFER: if (!rx_full_i) state_d = ST_REL;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_o       = 1'b0;
        wr_en_o     = 1'b0;
        step_o      = 1'b0;
        reload_o    = 1'b0;
        fill_done_o = 1'b0;
        commit_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: reload_o = 1'b1;
            ST_REQ: begin
                req_o = tx_empty_i;
                if (en && ack_i) begin
                    wr_en_o = 1'b1;
                    if (is_last_i) begin
                        fill_done_o = 1'b1;
                        reload_o    = 1'b1;
                    end else begin
                        step_o = 1'b1;
                    end
                end
            end
            ST_REL: ;
            ST_XFER: commit_o = !rx_full_i;
            default: ;
        endcase
    end

    // R1
    req_needs_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        req_o |-> tx_empty_i);

    // R1
    req_off_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en && !mode_on($past(mode_i))) |-> !req_o);

    // R2
    req_drop_on_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_o && ack_i) |=> !req_o);

    // R3
    wait_ack_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_REL && ack_i) |=> !req_o);

    // R6
    stall_no_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_XFER && rx_full_i) |-> (!req_o && !commit_o));

endmodule

// File: rtl/hdma_word_packer.sv
module hdma_word_packer #(
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned NUM_LANES = 2,
    localparam int unsigned LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int unsigned WORD_W = BYTE_W * NUM_LANES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        mode_i,
    input  logic              ack_i,
    input  logic [BYTE_W-1:0] hdata_i,
    output logic              req_o,
    input  logic              rd_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_full_o,
    output logic              tx_empty_o
);

    logic              wr_en, step, reload, fill_done, commit, is_last;
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] tx_word;

    hdma_hs_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mode_i      (mode_i),
        .ack_i       (ack_i),
        .tx_empty_i  (tx_empty_o),
        .rx_full_i   (rx_full_o),
        .is_last_i   (is_last),
        .req_o       (req_o),
        .wr_en_o     (wr_en),
        .step_o      (step),
        .reload_o    (reload),
        .fill_done_o (fill_done),
        .commit_o    (commit)
    );

    hdma_lane_ctr #(.NUM_LANES(NUM_LANES)) u_ctr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_i    (mode_i),
        .reload_i  (reload),
        .step_i    (step),
        .lane_o    (lane),
        .is_last_o (is_last)
    );

    hdma_byte_bank #(.BYTE_W(BYTE_W), .NUM_LANES(NUM_LANES)) u_bank (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_en_i     (wr_en),
        .lane_i      (lane),
        .din_i       (hdata_i),
        .fill_done_i (fill_done),
        .commit_i    (commit),
        .word_o      (tx_word),
        .tx_empty_o  (tx_empty_o)
    );

    hdma_rx_hold #(.WORD_W(WORD_W)) u_rx (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .commit_i  (commit),
        .word_i    (tx_word),
        .rd_i      (rd_i),
        .rx_word_o (rx_word_o),
        .rx_full_o (rx_full_o)
    );

endmodule

// File: tb/tb_hdma_word_packer.sv
module tb_hdma_word_packer;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic        ack;
    logic [7:0]  hdata;
    logic        req;
    logic        rd;
    logic [15:0] rx_word;
    logic        rx_full;
    logic        tx_empty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hdma_word_packer dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .mode_i     (mode),
        .ack_i      (ack),
        .hdata_i    (hdata),
        .req_o      (req),
        .rd_i       (rd),
        .rx_word_o  (rx_word),
        .rx_full_o  (rx_full),
        .tx_empty_o (tx_empty)
    );

    // fields: mode[27:26] hi[25:18] lo[17:10] dly[9:6] hold[5:4] rd_now[3] stall[2:0]
    localparam int NV = 10;
    localparam logic [27:0] VECS [NV] = '{
        {2'b10, 8'hA1, 8'h5C, 4'd0, 2'd0, 1'b1, 3'd0},
        {2'b10, 8'h3F, 8'hC2, 4'd2, 2'd1, 1'b0, 3'd0},
        {2'b10, 8'h77, 8'h08, 4'd1, 2'd0, 1'b1, 3'd3},
        {2'b01, 8'h00, 8'hE4, 4'd0, 2'd2, 1'b1, 3'd0},
        {2'b01, 8'h00, 8'h19, 4'd3, 2'd0, 1'b0, 3'd0},
        {2'b01, 8'h00, 8'hB6, 4'd0, 2'd1, 1'b1, 3'd2},
        {2'b10, 8'hF0, 8'h0F, 4'd1, 2'd1, 1'b0, 3'd0},
        {2'b10, 8'h55, 8'hAA, 4'd0, 2'd0, 1'b0, 3'd1},
        {2'b01, 8'h00, 8'hC3, 4'd2, 2'd0, 1'b1, 3'd3},
        {2'b10, 8'h81, 8'h7E, 4'd0, 2'd2, 1'b1, 3'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int hold);
        int w = 0;
        while (!req && w < 30) begin
            @(negedge clk);
            w++;
        end
        chk("R1 request raised", 32'(req), 32'd1);
        ack   = 1'b1;
        hdata = b;
        @(negedge clk);
        chk("R2 request dropped after ack", 32'(req), 32'd0);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R3 request low while ack held", 32'(req), 32'd0);
        end
        ack = 1'b0;
    endtask

    task automatic pulse_rd();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        logic [7:0]  exp_hi;
        logic [15:0] prev_word, exp_word;
        logic [1:0]  cur_mode;
        bit          pending;

        rst = 1'b1; mode = 2'b10; ack = 1'b0; hdata = '0; rd = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 rx_full in reset", 32'(rx_full), 32'd0);
        chk("R9 tx_empty in reset", 32'(tx_empty), 32'd1);
        chk("R9 req in reset", 32'(req), 32'd0);
        chk("R9 rx_word in reset", 32'(rx_word), 32'd0);
        rst = 1'b0;
        exp_hi = 8'h00; prev_word = '0; pending = 1'b0; cur_mode = 2'b10;

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VECS[i];
            if (v[27:26] != cur_mode) begin
                mode = 2'b00;
                repeat (2) @(negedge clk);
                chk("R1 req low in mode 00", 32'(req), 32'd0);
                mode = v[27:26];
                cur_mode = v[27:26];
            end
            if (cur_mode == 2'b10) begin
                send_byte(v[25:18], int'(v[5:4]));
                @(negedge clk);
                chk("R3 req back after ack low", 32'(req), 32'd1);
                chk("R4 tx_empty after high lane", 32'(tx_empty), 32'd1);
                exp_hi = v[25:18];
            end
            repeat (int'(v[9:6]) + $urandom_range(0, 2)) @(negedge clk);
            send_byte(v[17:10], int'(v[5:4]));
            @(negedge clk);
            exp_word = {exp_hi, v[17:10]};
            if (pending) begin
                chk("R6 stalled rx_word held", 32'(rx_word), 32'(prev_word));
                chk("R6 stalled tx_empty low", 32'(tx_empty), 32'd0);
                chk("R6 stalled req low", 32'(req), 32'd0);
                repeat (int'(v[2:0]) + $urandom_range(0, 2)) @(negedge clk);
                chk("R6 still stalled", 32'(rx_word), 32'(prev_word));
                pulse_rd();
                @(negedge clk);
            end
            chk("R5 R7 committed word", 32'(rx_word), 32'(exp_word));
            chk("R5 rx_full set", 32'(rx_full), 32'd1);
            chk("R5 tx_empty restored", 32'(tx_empty), 32'd1);
            prev_word = exp_word;
            pending = 1'b1;
            if (v[3]) begin
                pulse_rd();
                chk("R8 read clears full", 32'(rx_full), 32'd0);
                pending = 1'b0;
            end
        end

        // R9: reset in the middle of a 16-bit word
        mode = 2'b00;
        repeat (2) @(negedge clk);
        mode = 2'b10;
        send_byte(8'hEE, 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 mid-word reset tx_empty", 32'(tx_empty), 32'd1);
        chk("R9 mid-word reset rx_word", 32'(rx_word), 32'd0);
        chk("R9 mid-word reset req", 32'(req), 32'd0);
        rst = 1'b0;
        send_byte(8'h12, 0);
        @(negedge clk);
        send_byte(8'h34, 0);
        @(negedge clk);
        chk("R9 lane reload after reset", 32'(rx_word), 32'h1234);
        pulse_rd();

        // R1: acknowledges ignored while off
        mode = 2'b00;
        repeat (2) @(negedge clk);
        ack = 1'b1; hdata = 8'h77;
        repeat (3) begin
            @(negedge clk);
            chk("R1 req low, ack ignored", 32'(req), 32'd0);
        end
        chk("R1 tx_empty untouched", 32'(tx_empty), 32'd1);
        chk("R1 nothing committed", 32'(rx_full), 32'd0);
        ack = 1'b0;
        mode = 2'b11;
        repeat (3) @(negedge clk);
        chk("R1 req low in mode 11", 32'(req), 32'd0);

        // R7: 8-bit word keeps the high lane from before
        mode = 2'b01;
        send_byte(8'h99, 1);
        @(negedge clk);
        chk("R7 8-bit keeps high lane", 32'(rx_word), 32'h1299);
        pulse_rd();
        chk("R8 final read", 32'(rx_full), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule